// File: doc/BRIEF.md
# Flow-Through Synchronous SRAM with Lane Writes

This block is a synthesizable model of a single-ported synchronous static memory. Reads are flow-through: the edge that registers a read address also presents the word at the data outputs before the next edge. Writes are late by one cycle: the edge after the write command takes the write data. As a result, reads and writes can follow each other in any order with no idle cycles between them. The word is split into byte lanes. Each lane holds eight data bits and one parity bit, and each lane has its own active-low write strobe.

A command is accepted only when a clock-enable input is active, the sleep input is low, and three chip enables (two active-low, one active-high) all agree. The bidirectional bus is modelled as a data input, a data output and an output-enable flag. The output enable combines an asynchronous active-low request with masking from the sequencer. This masking turns the output off during a write's data cycle, during the first cycle after a deselect, and in sleep.

Top module: `flowsram`

## Requirements
- R1: A rising edge with `clk_en_n`=0 and `sleep`=0 carries a command only if `cs1_n`=0, `cs2`=1 and `cs3_n`=0. Otherwise that edge is a deselect, and `q_en` is 0 for the following cycle.
- R2: A selected edge with `wr_n`=0 registers a write to `addr`. The word on `d` at the next enabled edge is stored there.
- R3: Lane k is bits [9k+8:9k], with parity at bit 9k+8. It is written only if `lane_wr_n[k]`=0 at the write command. Lanes with a high strobe keep their old data and parity.
- R4: A selected edge with `wr_n`=1 registers a read. In the cycle right after that edge, `q` shows the word stored at that address.
- R5: A read registered at the data edge of a write to the same address returns the merged word: the new lanes plus the untouched old lanes.
- R6: An edge with `clk_en_n`=1 is ignored. Outputs and stored state hold, and a pending write takes its data at the next enabled edge.
- R7: `oe_n`=1 forces `q_en`=0 with no clock edge needed. `q` is all zeros whenever `q_en`=0.
- R8: `q_en` is 0 in the cycle after a write command (the write's data cycle).
- R9: `q_en` is 0 in the first cycle after a selected edge that follows a deselect edge or reset.
- R10: While `sleep`=1, commands and write data are ignored, `q_en` is 0, and stored words are preserved.
- R11: After reset, `q_en` is 0 and no write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the control state |
| clk_en_n | input | 1 | Active-low clock enable |
| cs1_n | input | 1 | Chip enable, active low |
| cs2 | input | 1 | Chip enable, active high |
| cs3_n | input | 1 | Chip enable, active low |
| wr_n | input | 1 | Active-low write command |
| lane_wr_n | input | 4 | Active-low per-lane write strobes |
| addr | input | 6 | Word address |
| d | input | 36 | Write data, four 9-bit lanes |
| oe_n | input | 1 | Asynchronous active-low output request |
| sleep | input | 1 | Hold mode: ignore commands, keep contents |
| q | output | 36 | Read data, zero when not enabled |
| q_en | output | 1 | Output drive enable |

## Verification
If the pending-write register is wrong, it appears at the ports on the first later read of the affected address. That read shows a wrong lane, a lane that should have been kept, or a word written late by a stall. If the read-state or deselect-tracking registers are wrong, `q_en` shows it in the very cycle after the edge that set them: it is high in a write data cycle or just after a deselect, or low on a valid read. A bench model steps the same command rules at each edge. Each cycle's `q_en` and `q` are compared against that model, so every error is caught within one cycle of the read that exposes it.

// File: rtl/flowsram_pkg.sv
`timescale 1ns/1ps
package flowsram_pkg;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2
  } cmd_e;

  // three-way chip enable agreement
  function automatic logic chip_hit(input logic a_n, input logic b, input logic c_n);
    return (!a_n) && b && (!c_n);
  endfunction

  // output gate: sequencer permission, async request, hold mode
  function automatic logic drive_ok(input logic live, input logic req_n, input logic hold);
    return live && !req_n && !hold;
  endfunction

endpackage

// File: rtl/flowsram_decode.sv
`timescale 1ns/1ps
module flowsram_decode
  import flowsram_pkg::*;
(
  input  logic clk_en_n,
  input  logic sleep,
  input  logic cs1_n,
  input  logic cs2,
  input  logic cs3_n,
  input  logic wr_n,
  output logic step,
  output logic sel_hit,
  output cmd_e cmd
);

  always_comb begin
    step    = !clk_en_n && !sleep;
    sel_hit = chip_hit(cs1_n, cs2, cs3_n);
    if (!sel_hit)   cmd = CMD_NONE;
    else if (!wr_n) cmd = CMD_WRITE;
    else            cmd = CMD_READ;
  end

endmodule

// File: rtl/flowsram_seq.sv
`timescale 1ns/1ps
module flowsram_seq
  import flowsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              sel_hit,
  input  cmd_e              cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  lane_wr_n,
  output logic              rd_live,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              commit,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [LANES-1:0]  wr_mask,
  output logic              resume_evt,
  output logic              pend
);

  cmd_e              cmd_q;
  logic              first_q;
  logic              desel_q;
  logic              pend_q;
  logic [ADDR_W-1:0] paddr_q;
  logic [LANES-1:0]  pmask_q;
  logic [ADDR_W-1:0] raddr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= CMD_NONE;
      first_q <= 1'b1;
      desel_q <= 1'b1;
      pend_q  <= 1'b0;
      paddr_q <= '0;
      pmask_q <= '0;
      raddr_q <= '0;
    end else if (step) begin
      cmd_q  <= cmd;
      pend_q <= (cmd == CMD_WRITE);
      if (cmd == CMD_WRITE) begin
        paddr_q <= addr;
        pmask_q <= ~lane_wr_n;
      end
      if (cmd == CMD_READ) raddr_q <= addr;
      if (sel_hit) first_q <= desel_q;
      desel_q <= !sel_hit;
    end
  end

  assign commit     = step && pend_q;
  assign wr_addr    = paddr_q;
  assign wr_mask    = pmask_q;
  assign rd_addr    = raddr_q;
  assign rd_live    = (cmd_q == CMD_READ) && !first_q;
  assign resume_evt = step && sel_hit && desel_q;
  assign pend       = pend_q;

  // R6
  stall_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && pend_q) |=> (pend_q && $stable(paddr_q) && $stable(pmask_q)));

  // R2
  wr_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cmd == CMD_WRITE) |=> (pend_q && paddr_q == $past(addr)));

endmodule

// File: rtl/flowsram_array.sv
`timescale 1ns/1ps
module flowsram_array #(
  parameter int ADDR_W    = 6,
  parameter int LANES     = 4,
  parameter int LANE_BITS = 9,
  localparam int DEPTH    = 1 << ADDR_W,
  localparam int WORD_W   = LANES * LANE_BITS
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [LANES-1:0]  wmask,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [LANE_BITS-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
      if (we && wmask[k]) store[waddr] <= wdata[k*LANE_BITS +: LANE_BITS];
    end

    assign rdata[k*LANE_BITS +: LANE_BITS] = store[raddr];
  end

endmodule

// File: rtl/flowsram.sv
`timescale 1ns/1ps
module flowsram
  import flowsram_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int LANES     = 4,
  parameter int LANE_BITS = 9,
  localparam int WORD_W   = LANES * LANE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en_n,
  input  logic              cs1_n,
  input  logic              cs2,
  input  logic              cs3_n,
  input  logic              wr_n,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] d,
  input  logic              oe_n,
  input  logic              sleep,
  output logic [WORD_W-1:0] q,
  output logic              q_en
);

  logic              step;
  logic              sel_hit;
  cmd_e              cmd;
  logic              rd_live;
  logic [ADDR_W-1:0] rd_addr;
  logic              commit;
  logic [ADDR_W-1:0] wr_addr;
  logic [LANES-1:0]  wr_mask;
  logic              resume_evt;
  logic              pend;
  logic [WORD_W-1:0] rdata;

  flowsram_decode u_dec (
    .clk_en_n (clk_en_n),
    .sleep    (sleep),
    .cs1_n    (cs1_n),
    .cs2      (cs2),
    .cs3_n    (cs3_n),
    .wr_n     (wr_n),
    .step     (step),
    .sel_hit  (sel_hit),
    .cmd      (cmd)
  );

  flowsram_seq #(.ADDR_W(ADDR_W), .LANES(LANES)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .step       (step),
    .sel_hit    (sel_hit),
    .cmd        (cmd),
    .addr       (addr),
    .lane_wr_n  (lane_wr_n),
    .rd_live    (rd_live),
    .rd_addr    (rd_addr),
    .commit     (commit),
    .wr_addr    (wr_addr),
    .wr_mask    (wr_mask),
    .resume_evt (resume_evt),
    .pend       (pend)
  );

  flowsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_BITS(LANE_BITS)) u_mem (
    .clk   (clk),
    .we    (commit),
    .waddr (wr_addr),
    .wmask (wr_mask),
    .wdata (d),
    .raddr (rd_addr),
    .rdata (rdata)
  );

  assign q_en = drive_ok(rd_live, oe_n, sleep);
  assign q    = q_en ? rdata : '0;

  // R1
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !sel_hit) |=> !q_en);

  // R8
  wphase_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cmd == CMD_WRITE) |=> !q_en);

  // R9
  resume_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_evt |=> !q_en);

  // R10
  sleep_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (!commit && !q_en));

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en_n && !sleep && !oe_n) ##1 (!sleep && !oe_n) |-> $stable(q));

  // R11
  reset_idle_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (!q_en && !pend));

endmodule

// File: tb/flowsram_test.sv
`timescale 1ns/1ps
module flowsram_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_en_n = 1'b0;
  logic        cs1_n = 1'b1;
  logic        cs2 = 1'b1;
  logic        cs3_n = 1'b0;
  logic        wr_n = 1'b1;
  logic [3:0]  lane_wr_n = 4'hF;
  logic [5:0]  addr = '0;
  logic [35:0] d = '0;
  logic        oe_n = 1'b0;
  logic        sleep = 1'b0;
  logic [35:0] q;
  logic        q_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  flowsram uut (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .cs1_n(cs1_n), .cs2(cs2),
    .cs3_n(cs3_n), .wr_n(wr_n), .lane_wr_n(lane_wr_n), .addr(addr), .d(d),
    .oe_n(oe_n), .sleep(sleep), .q(q), .q_en(q_en)
  );

  // bench model
  logic [35:0] m_mem [64];
  bit          m_pend, m_rd, m_first, m_desel;
  logic [5:0]  m_paddr, m_raddr;
  logic [3:0]  m_pmask;

  function automatic logic [35:0] lane_mix(logic [35:0] old_w, logic [35:0] new_w, logic [3:0] m);
    logic [35:0] r = old_w;
    for (int k = 0; k < 4; k++)
      if (m[k]) r[k*9 +: 9] = new_w[k*9 +: 9];
    return r;
  endfunction

  function automatic logic [35:0] pat(int a);
    return {4'(a), 32'(a * 32'h9E3779B1)};
  endfunction

  task automatic model_step();
    bit s;
    if (!clk_en_n && !sleep) begin
      s = !cs1_n && cs2 && !cs3_n;
      if (m_pend) m_mem[m_paddr] = lane_mix(m_mem[m_paddr], d, m_pmask);
      m_pend = 0;
      if (s && !wr_n) begin
        m_pend = 1; m_paddr = addr; m_pmask = ~lane_wr_n; m_rd = 0;
      end else if (s) begin
        m_rd = 1; m_raddr = addr;
      end else m_rd = 0;
      if (s) m_first = m_desel;
      m_desel = !s;
    end
  endtask

  task automatic compare(string tag);
    logic        e_en;
    logic [35:0] e_q;
    e_en = m_rd && !m_first && !oe_n && !sleep;
    e_q  = e_en ? m_mem[m_raddr] : 36'h0;
    checks++;
    if (q_en !== e_en || q !== e_q) begin
      errors++;
      $display("FAIL %s: q_en=%0b q=%h expected q_en=%0b q=%h", tag, q_en, q, e_en, e_q);
    end
  endtask

  task automatic cyc(string tag);
    @(posedge clk);
    model_step();
    #2;
    compare(tag);
    @(negedge clk);
  endtask

  task automatic idle();
    clk_en_n = 0; cs1_n = 1; cs2 = 1; cs3_n = 0; wr_n = 1; lane_wr_n = 4'hF;
    sleep = 0; oe_n = 0;
  endtask

  task automatic put_wr(int a, logic [3:0] bw);
    cs1_n = 0; cs2 = 1; cs3_n = 0; wr_n = 0; addr = 6'(a); lane_wr_n = bw;
  endtask

  task automatic put_rd(int a);
    cs1_n = 0; cs2 = 1; cs3_n = 0; wr_n = 1; addr = 6'(a);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    m_pend = 0; m_rd = 0; m_first = 1; m_desel = 1;
    m_paddr = '0; m_raddr = '0; m_pmask = '0;
    for (int i = 0; i < 64; i++) m_mem[i] = '0;
    idle();
    repeat (3) @(negedge clk);
    #1; compare("R11");
    rst_n = 1;
    @(negedge clk);
    cyc("R11");

    // fill array: each cycle carries the data of the previous command (R2)
    for (int a = 0; a < 64; a++) begin
      put_wr(a, 4'h0);
      d = (a == 0) ? 36'h0 : pat(a - 1);
      cyc("R8");
    end
    idle(); d = pat(63);
    cyc("R2");

    // reads after deselect: first masked (R9), rest visible (R4)
    put_rd(10); cyc("R9");
    put_rd(63); cyc("R2");
    put_rd(0);  cyc("R4");

    // partial write, read merged on the data edge (R3, R5)
    put_wr(5, 4'b1010); cyc("R8");
    d = 36'hA_BCDE_F123; put_rd(5); cyc("R5");
    put_rd(5); cyc("R3");

    // stall across a pending write (R6)
    put_wr(9, 4'h0); d = 36'h0; cyc("R8");
    clk_en_n = 1;
    for (int i = 0; i < 3; i++) begin
      d = 36'(64'h5_5555_5555 + i); put_rd(20 + i); cyc("R6");
    end
    clk_en_n = 0; d = 36'h3_1415_9265; put_rd(9); cyc("R6");
    clk_en_n = 1; put_rd(1); cyc("R6");
    cyc("R6");
    clk_en_n = 0; put_rd(9); cyc("R2");

    // each enable deselects (R1), then resume masked (R9)
    put_rd(9); cs1_n = 1; cyc("R1");
    put_rd(9); cs2 = 0;   cyc("R1");
    put_rd(9); cs3_n = 1; cyc("R1");
    put_rd(9); cyc("R9");
    put_rd(9); cyc("R4");

    // async output request (R7)
    oe_n = 1; #1; compare("R7");
    cyc("R7");
    oe_n = 0; #1; compare("R7");

    // sleep: commands and data ignored (R10)
    sleep = 1;
    for (int i = 0; i < 4; i++) begin
      put_wr(9, 4'h0); d = 36'hF_FFFF_FFFF; cyc("R10");
    end
    put_rd(9); cyc("R10");
    sleep = 0; put_rd(9); cyc("R10");
    put_rd(9); cyc("R10");

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      r = $urandom;
      clk_en_n  = (r[2:0] == 3'd0);
      cs1_n     = (r[6:3] == 4'd0);
      cs2       = (r[10:7] != 4'd0);
      cs3_n     = (r[14:11] == 4'd0);
      wr_n      = r[15];
      lane_wr_n = r[19:16];
      addr      = 6'(r[25:20] & 6'h0F);
      oe_n      = (r[28:26] == 3'd0);
      sleep     = (r[31:29] == 3'd0) && r[4];
      d         = {4'($urandom), 32'($urandom)};
      cyc("R4");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule